// File: doc/BRIEF.md
# Pseudo-SRAM synchronous burst controller

This block sits between an on-chip user port and a 16-bit pseudo-static RAM that offers a synchronous burst interface on a 23-bit address. After reset it performs a single configuration-register write through the memory's dedicated register-enable pin. That write selects fixed initial latency, the burst length and the address ordering. Only then does it start accepting user requests.

A user request names an address and says whether it is a read or a write. A flag marks a request as a single-word access. Each accepted request becomes one memory burst. The burst has an address-strobe cycle, then a fixed count of latency cycles, then a run of data cycles. For every data cycle the user port gives a per-word strobe, the word's memory address and, where the length is known, a last-word flag. In continuous mode the burst lasts as long as the user keeps its request asserted. Chip-enable is raised once the burst is over.

The memory samples all controls on the rising edge of the controller clock. The memory clock is gated at the pad by the clock-enable output.

Top module: `psram_burst_ctrl`

## Requirements
- R1: From reset until the configuration write has been issued, `req_ready` is low and `mem_ce_n` is high. Exactly one configuration write is issued after reset. It is a cycle with `mem_cre`, `mem_we_n`, `mem_adv_n` and `mem_ce_n` all asserted, and it comes before any user burst.
- R2: The configuration word is driven on `mem_adr` and has these fields:
  - bits [19:18] = 2'b10, the register select;
  - bit 14 = 1, fixed latency (0, variable latency, is the memory's reset default);
  - bits [13:11] = LATENCY;
  - bit 3 = 1 when wrap is enabled;
  - bits [2:0] = burst length code: 3'b001 for 4 words, 3'b010 for 8, 3'b011 for 16, 3'b100 for 32, 3'b111 for continuous.
  
  All other bits are 0.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The cycle after acceptance is the command cycle, with these pins:
  - `mem_ce_n` = 0 and `mem_adv_n` = 0 for that one cycle only;
  - `mem_adr` = the request address;
  - `mem_we_n` = 0 for a write and 1 for a read;
  - `mem_cre` = 0.
  
  Every burst begins with such a cycle.
- R4: The first data cycle is exactly LATENCY+1 cycles after the command cycle. Data cycles then follow back to back. No data strobe and no data drive occur before that cycle.
- R5: During a read, `mem_oe_n` is low from the cycle after the command cycle through the last data cycle, and `mem_dq_oe` stays low. In each data cycle `rd_valid` is high and `rd_data` equals `mem_dq_in`.
- R6: During a write, `wr_ready` and `mem_dq_oe` are high in each data cycle, and `mem_dq_out` carries `wr_data` of that same cycle.
- R7: When BURST_WORDS is non-zero, a burst that is not single carries exactly BURST_WORDS words, and `xfer_last` is high on the final word only. In continuous mode `xfer_last` stays low for bursts that are not single.
- R8: A single request carries exactly one word, with `xfer_last` high, in either mode.
- R9: With wrap enabled and a fixed length of L words, word k of a burst that starts at address A has address {A[22:log2 L], (A + k) mod L}, shown on `xfer_addr`.
- R10: In continuous mode, or with wrap disabled, word k has address A + k.
- R11: In continuous mode, a data cycle in which `req_valid` is low carries the burst's final word.
- R12: After the final data cycle, `mem_ce_n` is high in the next cycle, and `req_ready` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; in continuous mode, held high to keep the burst going |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_single | input | 1 | One-word access |
| req_addr | input | ADDR_W | Start word address |
| wr_data | input | DATA_W | Write word for the current data cycle |
| wr_ready | output | 1 | Write word consumed this cycle |
| rd_data | output | DATA_W | Read word of the current data cycle |
| rd_valid | output | 1 | Read word valid this cycle |
| xfer_addr | output | ADDR_W | Memory address of the current word |
| xfer_last | output | 1 | Final word of a single or fixed-length burst |
| mem_clk_en | output | 1 | Memory clock gate enable |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cre | output | 1 | Configuration-register enable |
| mem_adr | output | ADDR_W | Address / configuration word |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | DATA_W | Data from the memory |

## Verification
The memory model learns its latency, length and wrap mode only from the configuration word it decodes. A controller that mis-encodes a field, or that skips the register write, therefore reads and writes the wrong cycles or the wrong addresses, and read-back shows the damage. The bench starts wrapped bursts at mid-group offsets and at the top of the address space, where a design that carries into the upper bits or that counts one latency cycle too few or too many would corrupt data. Continuous bursts are stopped on a chosen word and cross aligned boundaries; a controller that ended one word late or wrapped there would return the wrong count or the wrong addresses. Single accesses in a fixed-length configuration check that a burst can be cut short after one word.

// File: rtl/psram_burst_pkg.sv
package psram_burst_pkg;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_CFG,
      ST_IDLE,
      ST_CMD,
      ST_LAT,
      ST_DATA
   } ctrl_state_t;

   localparam int CFG_SEL_LSB  = 18;
   localparam int CFG_FIX_BIT  = 14;
   localparam int CFG_LAT_LSB  = 11;
   localparam int CFG_WRAP_BIT = 3;

   function automatic logic [2:0] len_code(input int words);
      case (words)
         4:       return 3'b001;
         8:       return 3'b010;
         16:      return 3'b011;
         32:      return 3'b100;
         default: return 3'b111;
      endcase
   endfunction

endpackage

// File: rtl/psram_lat_timer.sv
module psram_lat_timer #(
   parameter int LATENCY = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int CW = $clog2(LATENCY + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= CW'(LATENCY - 1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/psram_burst_addr.sv
module psram_burst_addr #(
   parameter int ADDR_W      = 23,
   parameter int BURST_WORDS = 8,
   parameter bit WRAP        = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              step,
   output logic [ADDR_W-1:0] base_addr,
   output logic [ADDR_W-1:0] idx,
   output logic [ADDR_W-1:0] cur_addr
);
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
      end else if (load) begin
         base_q <= start_addr;
         idx_q  <= '0;
      end else if (step) begin
         idx_q  <= idx_q + 1'b1;
      end
   end

   generate
      if (WRAP && BURST_WORDS > 0) begin : g_wrap
         localparam int LW = $clog2(BURST_WORDS);
         logic [LW-1:0] off;
         assign off      = base_q[LW-1:0] + idx_q[LW-1:0];
         assign cur_addr = {base_q[ADDR_W-1:LW], off};
      end else begin : g_linear
         assign cur_addr = base_q + idx_q;
      end
   endgenerate

   assign base_addr = base_q;
   assign idx       = idx_q;
endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
   import psram_burst_pkg::*;
#(
   parameter int ADDR_W      = 23,
   parameter int DATA_W      = 16,
   parameter int LATENCY     = 5,
   parameter int BURST_WORDS = 8,
   parameter bit WRAP        = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_single,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic              xfer_last,
   output logic              mem_clk_en,
   output logic              mem_ce_n,
   output logic              mem_adv_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_cre,
   output logic [ADDR_W-1:0] mem_adr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam bit FIXED_LEN = (BURST_WORDS != 0);
   localparam logic [ADDR_W-1:0] CFG_WORD = ADDR_W'(
        (2 << CFG_SEL_LSB)
      | (1 << CFG_FIX_BIT)
      | (LATENCY << CFG_LAT_LSB)
      | (int'(WRAP) << CFG_WRAP_BIT)
      | int'(len_code(BURST_WORDS)));

   generate
      if (LATENCY < 1 || LATENCY > 7) begin : g_bad_latency
         $error("psram_burst_ctrl: LATENCY must lie in 1..7");
      end
      if (!(BURST_WORDS == 0 || BURST_WORDS == 4 || BURST_WORDS == 8 ||
            BURST_WORDS == 16 || BURST_WORDS == 32)) begin : g_bad_len
         $error("psram_burst_ctrl: BURST_WORDS must be 0, 4, 8, 16 or 32");
      end
      if (ADDR_W < 20) begin : g_bad_addr
         $error("psram_burst_ctrl: ADDR_W too narrow for the configuration word");
      end
   endgenerate

   ctrl_state_t       state_q;
   ctrl_state_t       state_d;
   logic              op_wr_q;
   logic              op_single_q;
   logic              accept;
   logic              in_data;
   logic              lat_expired;
   logic              len_done;
   logic              last_word;
   logic [ADDR_W-1:0] base_addr;
   logic [ADDR_W-1:0] idx;

   assign accept  = (state_q == ST_IDLE) && req_valid;
   assign in_data = (state_q == ST_DATA);

   psram_lat_timer #(.LATENCY(LATENCY)) u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (state_q == ST_CMD),
      .expired (lat_expired)
   );

   psram_burst_addr #(
      .ADDR_W      (ADDR_W),
      .BURST_WORDS (BURST_WORDS),
      .WRAP        (WRAP)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .start_addr (req_addr),
      .step       (in_data),
      .base_addr  (base_addr),
      .idx        (idx),
      .cur_addr   (xfer_addr)
   );

   generate
      if (FIXED_LEN) begin : g_fixed
         assign len_done  = (idx == ADDR_W'(BURST_WORDS - 1));
         assign xfer_last = in_data && last_word;
      end else begin : g_cont
         assign len_done  = ~req_valid;
         assign xfer_last = in_data && op_single_q;
      end
   endgenerate

   assign last_word = op_single_q || len_done;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_BOOT: state_d = ST_CFG;
         ST_CFG:  state_d = ST_IDLE;
         ST_IDLE: if (req_valid) state_d = ST_CMD;
         ST_CMD:  state_d = ST_LAT;
         ST_LAT:  if (lat_expired) state_d = ST_DATA;
         ST_DATA: if (last_word) state_d = ST_IDLE;
         default: state_d = ST_BOOT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_BOOT;
         op_wr_q     <= 1'b0;
         op_single_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            op_wr_q     <= req_write;
            op_single_q <= req_single;
         end
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign mem_ce_n   = (state_q == ST_BOOT) || (state_q == ST_IDLE);
   assign mem_clk_en = ~mem_ce_n;
   assign mem_adv_n  = !((state_q == ST_CFG) || (state_q == ST_CMD));
   assign mem_cre    = (state_q == ST_CFG);
   assign mem_we_n   = !((state_q == ST_CFG) || ((state_q == ST_CMD) && op_wr_q));
   assign mem_oe_n   = !(!op_wr_q && ((state_q == ST_LAT) || in_data));
   assign mem_adr    = (state_q == ST_CFG) ? CFG_WORD : base_addr;
   assign mem_dq_oe  = in_data && op_wr_q;
   assign mem_dq_out = wr_data;
   assign wr_ready   = in_data && op_wr_q;
   assign rd_valid   = in_data && !op_wr_q;
   assign rd_data    = mem_dq_in;
endmodule

// File: rtl/psram_burst_ctrl_chk.sv
module psram_burst_ctrl_chk #(
   parameter int LATENCY = 5
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic wr_ready,
   input logic rd_valid,
   input logic xfer_last,
   input logic mem_ce_n,
   input logic mem_adv_n,
   input logic mem_we_n,
   input logic mem_oe_n,
   input logic mem_cre,
   input logic mem_dq_oe
);
   logic       cfg_seen;
   logic [7:0] since_adv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_seen  <= 1'b0;
         since_adv <= '0;
      end else begin
         if (mem_cre) cfg_seen <= 1'b1;
         if (!mem_adv_n && !mem_cre) since_adv <= 8'd1;
         else if (since_adv != 8'd0 && since_adv != 8'hFF) since_adv <= since_adv + 8'd1;
      end
   end

   assert_cfg_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cre |-> (!mem_we_n && !mem_adv_n && !mem_ce_n));

   assert_cfg_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> cfg_seen);

   assert_adv_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_adv_n |=> mem_adv_n);

   assert_ce_with_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(mem_ce_n)) |-> !mem_adv_n);

   assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid || wr_ready || mem_dq_oe) |-> (since_adv >= 8'(LATENCY + 1)));

   assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_oe_n));

   assert_ce_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_last |=> mem_ce_n);
endmodule

bind psram_burst_ctrl psram_burst_ctrl_chk #(.LATENCY(LATENCY)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .wr_ready  (wr_ready),
   .rd_valid  (rd_valid),
   .xfer_last (xfer_last),
   .mem_ce_n  (mem_ce_n),
   .mem_adv_n (mem_adv_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_cre   (mem_cre),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_psram_burst_ctrl.sv
`timescale 1ns/100ps

module psram_model (
   input  logic        clk,
   input  logic        ce_n,
   input  logic        adv_n,
   input  logic        oe_n,
   input  logic        we_n,
   input  logic        cre,
   input  logic [22:0] adr,
   input  logic        dq_oe,
   input  logic [15:0] dq_out,
   output logic [15:0] dq_in,
   output int          cfg_writes,
   output bit          cfg_fixed,
   output int          cfg_lat,
   output int          cfg_len,
   output bit          cfg_wrap,
   output int          last_words,
   output int          n_chk,
   output int          n_fail
);
   logic [15:0] mem [int];
   bit          active;
   bit          wr;
   int          base;
   int          cyc;
   int          widx;

   initial begin
      cfg_writes = 0; cfg_fixed = 0; cfg_lat = 0; cfg_len = 0; cfg_wrap = 0;
      last_words = 0; n_chk = 0; n_fail = 0; active = 0; dq_in = 16'hFFFF;
   end

   function automatic int maddr(int i);
      if (cfg_len != 0 && cfg_wrap)
         return base - (base % cfg_len) + ((base % cfg_len) + i) % cfg_len;
      return base + i;
   endfunction

   task automatic mchk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s (memory model) actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   always @(posedge clk) begin
      if (!ce_n && !adv_n) begin
         if (cre) begin
            cfg_writes++;
            mchk(we_n == 1'b0, "R1", int'(we_n), 0);
            if (adr[19:18] == 2'b10) begin
               cfg_fixed = adr[14];
               cfg_lat   = int'(adr[13:11]);
               cfg_wrap  = adr[3];
               case (adr[2:0])
                  3'b001:  cfg_len = 4;
                  3'b010:  cfg_len = 8;
                  3'b011:  cfg_len = 16;
                  3'b100:  cfg_len = 32;
                  default: cfg_len = 0;
               endcase
            end
            active = 0;
         end else begin
            mchk(cfg_fixed, "R1", int'(cfg_fixed), 1);
            base = int'(adr); wr = !we_n; cyc = 1; widx = 0; active = 1;
         end
      end else if (active && ce_n) begin
         active = 0;
         last_words = widx;
      end else if (active) begin
         if (cyc >= cfg_lat + 1) begin
            if (wr) begin
               mchk(dq_oe == 1'b1, "R6", int'(dq_oe), 1);
               mem[maddr(widx)] = dq_out;
            end else begin
               mchk(oe_n == 1'b0, "R5", int'(oe_n), 0);
            end
            widx++;
         end else begin
            mchk(dq_oe == 1'b0, "R4", int'(dq_oe), 0);
         end
         cyc++;
      end
      if (active && !wr && cyc >= cfg_lat + 1)
         dq_in <= mem.exists(maddr(widx)) ? mem[maddr(widx)] : 16'h0000;
      else
         dq_in <= 16'hFFFF;
   end
endmodule

module test_psram_burst_ctrl;
   localparam int LAT = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   // instance A: fixed length 8, wrap
   logic        a_req_valid = 0, a_req_write = 0, a_req_single = 0;
   logic [22:0] a_req_addr = '0;
   logic [15:0] a_wr_data = '0;
   logic        a_req_ready, a_wr_ready, a_rd_valid, a_xfer_last, a_clk_en;
   logic [15:0] a_rd_data, a_dq_out, a_dq_in;
   logic [22:0] a_xfer_addr, a_mem_adr;
   logic        a_ce_n, a_adv_n, a_oe_n, a_we_n, a_cre, a_dq_oe;
   int          ma_cw, ma_lat, ma_len, ma_last, ma_chk, ma_fail;
   bit          ma_fix, ma_wrap;

   // instance B: continuous
   logic        b_req_valid = 0, b_req_write = 0, b_req_single = 0;
   logic [22:0] b_req_addr = '0;
   logic [15:0] b_wr_data = '0;
   logic        b_req_ready, b_wr_ready, b_rd_valid, b_xfer_last, b_clk_en;
   logic [15:0] b_rd_data, b_dq_out, b_dq_in;
   logic [22:0] b_xfer_addr, b_mem_adr;
   logic        b_ce_n, b_adv_n, b_oe_n, b_we_n, b_cre, b_dq_oe;
   int          mb_cw, mb_lat, mb_len, mb_last, mb_chk, mb_fail;
   bit          mb_fix, mb_wrap;

   logic [15:0] shadow_a [int];
   logic [15:0] shadow_b [int];

   psram_burst_ctrl #(.LATENCY(LAT), .BURST_WORDS(8), .WRAP(1'b1)) i_psram_burst_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(a_req_valid), .req_ready(a_req_ready),
      .req_write(a_req_write), .req_single(a_req_single), .req_addr(a_req_addr),
      .wr_data(a_wr_data), .wr_ready(a_wr_ready), .rd_data(a_rd_data), .rd_valid(a_rd_valid),
      .xfer_addr(a_xfer_addr), .xfer_last(a_xfer_last), .mem_clk_en(a_clk_en),
      .mem_ce_n(a_ce_n), .mem_adv_n(a_adv_n), .mem_oe_n(a_oe_n), .mem_we_n(a_we_n),
      .mem_cre(a_cre), .mem_adr(a_mem_adr), .mem_dq_out(a_dq_out), .mem_dq_oe(a_dq_oe),
      .mem_dq_in(a_dq_in));

   psram_model u_mem_a (
      .clk(clk), .ce_n(a_ce_n), .adv_n(a_adv_n), .oe_n(a_oe_n), .we_n(a_we_n), .cre(a_cre),
      .adr(a_mem_adr), .dq_oe(a_dq_oe), .dq_out(a_dq_out), .dq_in(a_dq_in),
      .cfg_writes(ma_cw), .cfg_fixed(ma_fix), .cfg_lat(ma_lat), .cfg_len(ma_len),
      .cfg_wrap(ma_wrap), .last_words(ma_last), .n_chk(ma_chk), .n_fail(ma_fail));

   psram_burst_ctrl #(.LATENCY(LAT), .BURST_WORDS(0), .WRAP(1'b1)) i_psram_burst_ctrl_cont (
      .clk(clk), .rst_n(rst_n), .req_valid(b_req_valid), .req_ready(b_req_ready),
      .req_write(b_req_write), .req_single(b_req_single), .req_addr(b_req_addr),
      .wr_data(b_wr_data), .wr_ready(b_wr_ready), .rd_data(b_rd_data), .rd_valid(b_rd_valid),
      .xfer_addr(b_xfer_addr), .xfer_last(b_xfer_last), .mem_clk_en(b_clk_en),
      .mem_ce_n(b_ce_n), .mem_adv_n(b_adv_n), .mem_oe_n(b_oe_n), .mem_we_n(b_we_n),
      .mem_cre(b_cre), .mem_adr(b_mem_adr), .mem_dq_out(b_dq_out), .mem_dq_oe(b_dq_oe),
      .mem_dq_in(b_dq_in));

   psram_model u_mem_b (
      .clk(clk), .ce_n(b_ce_n), .adv_n(b_adv_n), .oe_n(b_oe_n), .we_n(b_we_n), .cre(b_cre),
      .adr(b_mem_adr), .dq_oe(b_dq_oe), .dq_out(b_dq_out), .dq_in(b_dq_in),
      .cfg_writes(mb_cw), .cfg_fixed(mb_fix), .cfg_lat(mb_lat), .cfg_len(mb_len),
      .cfg_wrap(mb_wrap), .last_words(mb_last), .n_chk(mb_chk), .n_fail(mb_fail));

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d",
               n_checks + ma_chk + mb_chk, n_fails + ma_fail + mb_fail);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
         summary();
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic [15:0] pat(input logic [22:0] a, input int seed);
      return 16'(a[15:0] * 16'd7) ^ 16'(seed * 16'h1111) ^ 16'h3C5A;
   endfunction

   function automatic logic [22:0] wrap8(input logic [22:0] s, input int w);
      return {s[22:3], 3'(int'(s[2:0]) + w)};
   endfunction

   // fixed-length instance: one request, full per-cycle checking
   task automatic run_a(input bit wr, input bit single, input logic [22:0] addr,
                        input int nexp, input int seed);
      int lat_cnt = 0;
      int words = 0;
      int lastpos = -1;
      int lasts = 0;
      bit done = 0;
      logic [22:0] ea;
      string rq;
      rq = single ? "R8" : "R7";
      @(negedge clk);
      a_req_valid = 1; a_req_write = wr; a_req_single = single; a_req_addr = addr;
      for (int g = 0; g < 100 && !a_req_ready; g++) @(negedge clk);
      @(negedge clk);
      a_req_valid = 0;
      check(a_adv_n == 0 && a_ce_n == 0 && a_cre == 0, "R3 strobe", {a_adv_n, a_ce_n, a_cre}, 0);
      check(a_mem_adr == addr, "R3 address", a_mem_adr, addr);
      check(a_we_n == !wr, "R3 write enable", a_we_n, !wr);
      for (int c = 0; c < 200 && !done; c++) begin
         @(negedge clk);
         lat_cnt++;
         if (a_wr_ready || a_rd_valid) begin
            if (words == 0) check(lat_cnt == LAT + 1, "R4", lat_cnt, LAT + 1);
            ea = single ? addr : wrap8(addr, words);
            check(a_xfer_addr == ea, single ? "R8 address" : "R9", a_xfer_addr, ea);
            if (wr) begin
               check(a_wr_ready && a_dq_oe && a_oe_n, "R6", {a_wr_ready, a_dq_oe, a_oe_n}, 3'b111);
               a_wr_data = pat(ea, seed);
               shadow_a[int'(ea)] = a_wr_data;
            end else begin
               check(a_rd_valid && !a_dq_oe && !a_oe_n, "R5 pins", {a_rd_valid, a_dq_oe, a_oe_n}, 3'b100);
               check(a_rd_data == shadow_a[int'(ea)], "R5 data", a_rd_data, shadow_a[int'(ea)]);
            end
            if (a_xfer_last) begin
               lasts++;
               lastpos = words;
               done = 1;
            end
            words++;
         end
      end
      check(words == nexp, rq, words, nexp);
      check(lasts == 1 && lastpos == nexp - 1, {rq, " last flag"}, lastpos, nexp - 1);
      @(negedge clk);
      check(a_ce_n == 1 && a_req_ready == 1, "R12", {a_ce_n, a_req_ready}, 2'b11);
      @(negedge clk);
      check(ma_last == nexp, {rq, " memory word count"}, ma_last, nexp);
   endtask

   // continuous instance: the request is held until nwords words have passed
   task automatic run_b(input bit wr, input logic [22:0] addr, input int nwords, input int seed);
      int words = 0;
      int lasts = 0;
      bit seen = 0;
      logic [22:0] ea;
      @(negedge clk);
      b_req_valid = 1; b_req_write = wr; b_req_single = 0; b_req_addr = addr;
      for (int g = 0; g < 100 && !b_req_ready; g++) @(negedge clk);
      for (int c = 0; c < 300; c++) begin
         @(negedge clk);
         if (b_wr_ready || b_rd_valid) begin
            seen = 1;
            ea = addr + 23'(words);
            check(b_xfer_addr == ea, "R10", b_xfer_addr, ea);
            if (wr) begin
               b_wr_data = pat(ea, seed);
               shadow_b[int'(ea)] = b_wr_data;
            end else begin
               check(b_rd_data == shadow_b[int'(ea)], "R5 data (continuous)", b_rd_data, shadow_b[int'(ea)]);
            end
            if (b_xfer_last) lasts++;
            words++;
            if (words == nwords) b_req_valid = 0;
         end else if (seen && b_ce_n) begin
            break;
         end
      end
      check(words == nwords, "R11", words, nwords);
      check(lasts == 0, "R7 continuous last flag", lasts, 0);
      check(b_ce_n == 1 && b_req_ready == 1, "R12 continuous", {b_ce_n, b_req_ready}, 2'b11);
      @(negedge clk);
      check(mb_last == nwords, "R11 memory word count", mb_last, nwords);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(a_req_ready == 0 && a_ce_n == 1, "R1 reset state", {a_req_ready, a_ce_n}, 2'b01);
      check(b_req_ready == 0 && b_ce_n == 1, "R1 reset state", {b_req_ready, b_ce_n}, 2'b01);
      rst_n = 1;

      run_a(1, 0, 23'h000105, 8, 1);
      check(ma_cw == 1, "R1 one config write", ma_cw, 1);
      check(ma_fix == 1 && ma_lat == LAT, "R2 latency fields", {ma_fix, 8'(ma_lat)}, {1'b1, 8'(LAT)});
      check(ma_len == 8 && ma_wrap == 1, "R2 length and wrap", {8'(ma_len), ma_wrap}, {8'd8, 1'b1});
      run_a(0, 0, 23'h000105, 8, 0);
      run_a(0, 0, 23'h000100, 8, 0);
      run_a(1, 0, 23'h7FFFFC, 8, 2);
      run_a(0, 0, 23'h7FFFF8, 8, 0);
      run_a(1, 1, 23'h002003, 1, 3);
      run_a(0, 1, 23'h002003, 1, 0);
      run_a(0, 1, 23'h000102, 1, 0);
      run_a(0, 0, 23'h002000, 8, 0);
      check(ma_cw == 1, "R1 no further config write", ma_cw, 1);

      check(mb_cw == 1 && mb_fix == 1, "R1 continuous config", {8'(mb_cw), mb_fix}, {8'd1, 1'b1});
      check(mb_len == 0 && mb_lat == LAT, "R2 continuous code", {8'(mb_len), 8'(mb_lat)}, {8'd0, 8'(LAT)});
      run_b(1, 23'h000006, 5, 4);
      run_b(0, 23'h000006, 5, 0);
      run_b(1, 23'h0001FE, 9, 5);
      run_b(0, 23'h0001FE, 9, 0);
      run_b(0, 23'h000007, 2, 0);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule